// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block turns a single memory request issued on behalf of a whole warp into the fewest aligned memory transactions that cover it. A request carries one address for each lane, a mask that says which lanes take part, and one access width shared by every lane. The block captures all of this in one handshake. It then sends transactions out one at a time. Each transaction names an aligned base address, a segment size of 32, 64 or 128 bytes, and the set of lanes it serves.

Each transaction is grouped around the lowest-numbered lane that has not been served yet. That lane picks a 128-byte aligned segment, and every other unserved lane that falls in the same segment joins it. The segment then shrinks to an aligned 64-byte or 32-byte window when all the bytes it covers fit inside one. A unit-stride 4-byte pattern therefore costs one transaction, while a pattern with a wide stride costs one transaction per lane. The request port stays closed until the last transaction has been accepted downstream. A `done` pulse marks the end of each request.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1 and both `txn_valid` and `done` are 0.
- R2: Thirty-two active 4-byte lanes at addresses base+4·i, with base 128-byte aligned, produce exactly one transaction: that base, size code 2 (128 bytes) and mask 0xFFFFFFFF.
- R3: Each transaction is led by the lowest-numbered unserved active lane. Its mask contains exactly those unserved active lanes whose address bits above bit 6 equal the leader's.
- R4: When every byte touched by a transaction lies in one aligned 32-byte window, the transaction has size code 0 and the base of that window.
- R5: When the touched bytes fit in one aligned 64-byte window but not in a 32-byte one, the transaction has size code 1 and the base of the 64-byte window.
- R6: Lanes that each sit in a different 128-byte segment produce one transaction per lane, issued in ascending lane order, with `txn_last` set only on the final one.
- R7: Lanes whose mask bit is 0 never appear in a transaction mask and do not affect the segment or the size that is chosen.
- R8: A request with an all-zero mask produces no transaction. `done` is high in the cycle after acceptance and `req_ready` is high again in the cycle after that.
- R9: `req_ready` is 0 from acceptance until the last transaction has been accepted. A request offered during that time is not taken and has no effect on the transactions issued.
- R10: While `txn_valid` is 1 and `txn_ready` is 0, the base, size, mask and last flag stay constant.
- R11: `req_size` = k means accesses of 2^k bytes (k from 0 to 7). The low k address bits are ignored, and a 64-byte or 128-byte access covers its whole aligned window.
- R12: `done` is high for exactly one cycle per request. For a non-empty request, that cycle is the one in which the transaction with `txn_last` = 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can take a request |
| req_addr | input | LANES·ADDR_W | Lane addresses, lane i in bits [i·ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active lanes, bit i for lane i |
| req_size | input | 3 | log2 of the per-lane access width in bytes |
| txn_valid | output | 1 | A transaction is presented |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_base | output | ADDR_W | Aligned base address of the transaction |
| txn_size | output | 2 | 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes |
| txn_mask | output | LANES | Lanes served by this transaction |
| txn_last | output | 1 | This is the final transaction of the request |
| done | output | 1 | Request completes in this cycle |

## Verification
The bench drives a unit-stride word pattern, which has to collapse into a single full segment. It drives narrower clusters that have to shrink to 64 or 32 bytes, and these show whether the size choice looks at the touched chunks or only at the segment tag. An interleaved two-segment pattern with lane 0 inactive shows whether the leader is really the lowest unserved active lane. A 256-byte stride across all lanes has to split into 32 transactions in lane order. Byte-wide, 8-byte, 64-byte and 128-byte accesses check that the access width widens coverage and that the low address bits are ignored. An empty mask and a request offered while the block is busy and stalled check completion and input blocking.

// File: rtl/coal_pkg.sv
package coal_pkg;
    // Width of the per-lane access size code (log2 of bytes, 0..7).
    localparam int ACC_SZ_W = 3;
    // Width of the transaction size code (log2 of bytes / 32).
    localparam int TXN_SZ_W = 2;

    typedef enum logic [TXN_SZ_W-1:0] {
        TXN_32B  = 2'd0,
        TXN_64B  = 2'd1,
        TXN_128B = 2'd2
    } txn_size_e;
endpackage

// File: rtl/coal_leader.sv
// Picks the lowest-numbered set bit of a lane mask.
module coal_leader #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] lane_mask,
    output logic [IDX_W-1:0] lead_idx,
    output logic             lead_any
);
    always_comb begin
        lead_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lane_mask[i]) lead_idx = i[IDX_W-1:0];
        end
        lead_any = |lane_mask;
    end
endmodule

// File: rtl/coal_lane_match.sv
// Per-lane test: does this lane belong to the selected segment, and which
// 32-byte chunks of that segment does its access touch.
module coal_lane_match #(
    parameter int ADDR_W     = 32,
    parameter int SEG_LSB    = 7,
    parameter int CHUNK_LSB  = 5,
    parameter int NUM_CHUNKS = 4,
    parameter int SZ_W       = 3,
    localparam int TAG_W     = ADDR_W - SEG_LSB,
    localparam int CIDX_W    = $clog2(NUM_CHUNKS)
) (
    input  logic [ADDR_W-1:0]     lane_addr,
    input  logic [SZ_W-1:0]       acc_size,
    input  logic [TAG_W-1:0]      seg_sel,
    input  logic                  lane_pend,
    output logic                  hit,
    output logic [NUM_CHUNKS-1:0] chunks
);
    logic [CIDX_W-1:0] chunk_idx;
    logic              unused_low;
    int                span_sh;

    assign chunk_idx  = lane_addr[SEG_LSB-1:CHUNK_LSB];
    assign unused_low = ^lane_addr[CHUNK_LSB-1:0];
    assign hit        = lane_pend && (lane_addr[ADDR_W-1:SEG_LSB] == seg_sel);

    always_comb begin
        // Accesses wider than a chunk cover an aligned group of chunks.
        span_sh = (int'(acc_size) > CHUNK_LSB) ? int'(acc_size) - CHUNK_LSB : 0;
        if (span_sh > CIDX_W) span_sh = CIDX_W;
        for (int j = 0; j < NUM_CHUNKS; j++) begin
            chunks[j] = ((j >> span_sh) == (int'(chunk_idx) >> span_sh));
        end
    end
endmodule

// File: rtl/coal_span_select.sv
// Chooses the smallest aligned power-of-two group of chunks that holds every
// touched chunk, and forms the transaction base and size code from it.
module coal_span_select #(
    parameter int ADDR_W     = 32,
    parameter int SEG_LSB    = 7,
    parameter int CHUNK_LSB  = 5,
    parameter int NUM_CHUNKS = 4,
    parameter int SZ_W       = 2,
    localparam int TAG_W     = ADDR_W - SEG_LSB,
    localparam int CIDX_W    = $clog2(NUM_CHUNKS)
) (
    input  logic [TAG_W-1:0]      seg_tag,
    input  logic [NUM_CHUNKS-1:0] chunk_set,
    output logic [ADDR_W-1:0]     base,
    output logic [SZ_W-1:0]       size_code
);
    logic [CIDX_W-1:0]     lo_chunk;
    logic [CIDX_W-1:0]     first_chunk;
    logic [NUM_CHUNKS-1:0] grp_mask;
    logic                  found;
    int                    level;

    always_comb begin
        lo_chunk = '0;
        for (int j = NUM_CHUNKS - 1; j >= 0; j--) begin
            if (chunk_set[j]) lo_chunk = j[CIDX_W-1:0];
        end
        found = 1'b0;
        level = CIDX_W;
        grp_mask = '0;
        for (int l = 0; l <= CIDX_W; l++) begin
            for (int j = 0; j < NUM_CHUNKS; j++) begin
                grp_mask[j] = ((j >> l) == (int'(lo_chunk) >> l));
            end
            if (!found && ((chunk_set & ~grp_mask) == '0)) begin
                found = 1'b1;
                level = l;
            end
        end
        first_chunk = CIDX_W'((int'(lo_chunk) >> level) << level);
        base        = {seg_tag, first_chunk, {CHUNK_LSB{1'b0}}};
        size_code   = SZ_W'(level);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES       = 32,
    parameter int ADDR_W      = 32,
    parameter int SEG_BYTES   = 128,
    parameter int CHUNK_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    input  logic [ACC_SZ_W-1:0]     req_size,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [TXN_SZ_W-1:0]     txn_size,
    output logic [LANES-1:0]        txn_mask,
    output logic                    txn_last,
    output logic                    done
);
    localparam int SEG_LSB    = $clog2(SEG_BYTES);
    localparam int CHUNK_LSB  = $clog2(CHUNK_BYTES);
    localparam int NUM_CHUNKS = SEG_BYTES / CHUNK_BYTES;
    localparam int IDX_W      = $clog2(LANES);
    localparam int TAG_W      = ADDR_W - SEG_LSB;

    typedef struct packed {
        logic                    busy;
        logic [LANES-1:0]        pend;
        logic [ACC_SZ_W-1:0]     size;
        logic [LANES*ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic [IDX_W-1:0]      lead_idx;
    logic                  lead_any;
    logic [TAG_W-1:0]      seg_sel;
    logic [LANES-1:0]      join_vec;
    logic [NUM_CHUNKS-1:0] lane_chunks [LANES];
    logic [NUM_CHUNKS-1:0] chunk_or;
    logic [LANES-1:0]      remaining;

    coal_leader #(.LANES(LANES)) u_leader (
        .lane_mask (cur_q.pend),
        .lead_idx  (lead_idx),
        .lead_any  (lead_any)
    );

    assign seg_sel = cur_q.addr[int'(lead_idx)*ADDR_W + SEG_LSB +: TAG_W];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        coal_lane_match #(
            .ADDR_W     (ADDR_W),
            .SEG_LSB    (SEG_LSB),
            .CHUNK_LSB  (CHUNK_LSB),
            .NUM_CHUNKS (NUM_CHUNKS),
            .SZ_W       (ACC_SZ_W)
        ) u_match (
            .lane_addr (cur_q.addr[g*ADDR_W +: ADDR_W]),
            .acc_size  (cur_q.size),
            .seg_sel   (seg_sel),
            .lane_pend (cur_q.pend[g]),
            .hit       (join_vec[g]),
            .chunks    (lane_chunks[g])
        );
    end

    always_comb begin
        chunk_or = '0;
        for (int i = 0; i < LANES; i++) begin
            if (join_vec[i]) chunk_or = chunk_or | lane_chunks[i];
        end
    end

    coal_span_select #(
        .ADDR_W     (ADDR_W),
        .SEG_LSB    (SEG_LSB),
        .CHUNK_LSB  (CHUNK_LSB),
        .NUM_CHUNKS (NUM_CHUNKS),
        .SZ_W       (TXN_SZ_W)
    ) u_span (
        .seg_tag   (seg_sel),
        .chunk_set (chunk_or),
        .base      (txn_base),
        .size_code (txn_size)
    );

    assign remaining = cur_q.pend & ~join_vec;
    assign txn_mask  = join_vec;
    assign txn_valid = cur_q.busy && lead_any;
    assign txn_last  = txn_valid && (remaining == '0);
    assign req_ready = !cur_q.busy;

    always_comb begin
        nxt_d = cur_q;
        done  = 1'b0;
        if (!cur_q.busy) begin
            if (req_valid) begin
                nxt_d.busy = 1'b1;
                nxt_d.pend = req_mask;
                nxt_d.size = req_size;
                nxt_d.addr = req_addr;
            end
        end else if (!lead_any) begin
            // Empty request: finish one cycle after acceptance.
            nxt_d.busy = 1'b0;
            done       = 1'b1;
        end else if (txn_ready) begin
            nxt_d.pend = remaining;
            if (remaining == '0) begin
                nxt_d.busy = 1'b0;
                done       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/warp_coalescer_checker.sv
module warp_coalescer_checker #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_base,
    input logic [1:0]        txn_size,
    input logic [LANES-1:0]  txn_mask,
    input logic              txn_last,
    input logic              done
);
    a_r9_closed_while_issuing: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_size)
                                       && $stable(txn_mask) && $stable(txn_last)));

    a_r4_base_aligned_32: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_size == 2'd0) |-> (txn_base[4:0] == 5'd0));

    a_r5_base_aligned_64: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_size == 2'd1) |-> (txn_base[5:0] == 6'd0));

    a_r2_base_aligned_128: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_size == 2'd2) |-> (txn_base[6:0] == 7'd0));

    a_r3_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask != '0) && (txn_size != 2'd3)));

    a_r6_lanes_served_once: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && !txn_last) |=> (txn_valid && ((txn_mask & $past(txn_mask)) == '0)));

    a_r12_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!txn_valid || (txn_ready && txn_last)));

    a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
endmodule

bind warp_coalescer warp_coalescer_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_base  (txn_base),
    .txn_size  (txn_size),
    .txn_mask  (txn_mask),
    .txn_last  (txn_last),
    .done      (done)
);

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 32;
    localparam int ADDR_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES*ADDR_W-1:0] req_addr;
    logic [LANES-1:0]        req_mask = '0;
    logic [2:0]              req_size = 3'd2;
    logic                    txn_valid;
    logic                    txn_ready = 1'b1;
    logic [ADDR_W-1:0]       txn_base;
    logic [1:0]              txn_size;
    logic [LANES-1:0]        txn_mask;
    logic                    txn_last;
    logic                    done;

    logic [ADDR_W-1:0] a [LANES];

    int n_checks = 0;
    int n_fail = 0;

    logic [ADDR_W-1:0] rb [64];
    logic [1:0]        rs [64];
    logic [LANES-1:0]  rm [64];
    logic              rl [64];
    int                n_tx;
    int                n_done;
    logic              last_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = a[i];
    end

    warp_coalescer u_warp_coalescer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_mask  (req_mask),
        .req_size  (req_size),
        .txn_valid (txn_valid),
        .txn_ready (txn_ready),
        .txn_base  (txn_base),
        .txn_size  (txn_size),
        .txn_mask  (txn_mask),
        .txn_last  (txn_last),
        .done      (done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [ADDR_W-1:0] base, input int stride);
        for (int i = 0; i < LANES; i++) a[i] = base + ADDR_W'(i * stride);
    endtask

    task automatic send_req(input logic [LANES-1:0] m, input logic [2:0] sz);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_mask  = m;
        req_size  = sz;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Starts at the negedge after acceptance; ends one negedge after the last one.
    task automatic collect();
        bit fin = 0;
        n_tx = 0;
        n_done = 0;
        last_done = 1'b0;
        for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
            if (done) n_done++;
            if (txn_valid && txn_ready) begin
                rb[n_tx] = txn_base;
                rs[n_tx] = txn_size;
                rm[n_tx] = txn_mask;
                rl[n_tx] = txn_last;
                if (txn_last) begin
                    last_done = done;
                    fin = 1;
                end
                n_tx++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 txn_valid", 64'(txn_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
    endtask

    task automatic t_unit_stride();
        fill(32'h0000_1000, 4);
        send_req('1, 3'd2);
        collect();
        chk("R2 count", 64'(n_tx), 64'd1);
        chk("R2 base", 64'(rb[0]), 64'h1000);
        chk("R2 size", 64'(rs[0]), 64'd2);
        chk("R2 mask", 64'(rm[0]), 64'hFFFF_FFFF);
        chk("R12 done with last", 64'(last_done), 64'd1);
        chk("R12 single done", 64'(n_done), 64'd1);
    endtask

    task automatic t_small_32();
        fill(32'h0000_9000, 512);
        for (int i = 0; i < 8; i++) a[i] = 32'h0000_2040 + ADDR_W'(4 * i);
        send_req(32'h0000_00FF, 3'd2);
        collect();
        chk("R4 count", 64'(n_tx), 64'd1);
        chk("R4 base", 64'(rb[0]), 64'h2040);
        chk("R4 size", 64'(rs[0]), 64'd0);
        chk("R7 inactive lanes excluded", 64'(rm[0]), 64'h0000_00FF);
    endtask

    task automatic t_small_64();
        fill(32'h0000_3040, 4);
        send_req(32'h0000_FFFF, 3'd2);
        collect();
        chk("R5 count", 64'(n_tx), 64'd1);
        chk("R5 base", 64'(rb[0]), 64'h3040);
        chk("R5 size", 64'(rs[0]), 64'd1);
        chk("R5 mask", 64'(rm[0]), 64'h0000_FFFF);
    endtask

    task automatic t_leader_order();
        for (int i = 0; i < LANES; i++)
            a[i] = ((i % 2) == 0 ? 32'h0000_4000 : 32'h0000_5000) + ADDR_W'(4 * i);
        send_req(32'hFFFF_FFFE, 3'd2);
        collect();
        chk("R3 count", 64'(n_tx), 64'd2);
        chk("R3 first base", 64'(rb[0]), 64'h5000);
        chk("R3 first mask", 64'(rm[0]), 64'hAAAA_AAAA);
        chk("R3 first not last", 64'(rl[0]), 64'd0);
        chk("R3 second base", 64'(rb[1]), 64'h4000);
        chk("R7 second mask", 64'(rm[1]), 64'h5555_5554);
        chk("R3 second size", 64'(rs[1]), 64'd2);
    endtask

    task automatic t_scatter();
        int bad = 0;
        fill(32'h0001_0000, 256);
        send_req('1, 3'd2);
        collect();
        chk("R6 count", 64'(n_tx), 64'd32);
        for (int k = 0; k < 32; k++) begin
            if (rb[k] !== a[k] || rs[k] !== 2'd0 || rm[k] !== (32'd1 << k)
                || rl[k] !== (k == 31)) begin
                bad++;
                $display("FAIL R6 txn %0d actual=%0h/%0d/%0h expected=%0h/0/%0h",
                         k, rb[k], rs[k], rm[k], a[k], 32'd1 << k);
            end
        end
        n_checks++;
        if (bad != 0) n_fail++;
        chk("R12 scatter done", 64'(n_done), 64'd1);
    endtask

    task automatic t_empty();
        send_req('0, 3'd2);
        chk("R8 no txn", 64'(txn_valid), 64'd0);
        chk("R8 done", 64'(done), 64'd1);
        @(negedge clk);
        chk("R8 done once", 64'(done), 64'd0);
        chk("R8 ready again", 64'(req_ready), 64'd1);
    endtask

    task automatic t_busy_stall();
        for (int i = 0; i < LANES; i++)
            a[i] = (i < 16) ? 32'h0000_A000 + ADDR_W'(4 * i) : 32'h0000_B000 + ADDR_W'(4 * (i - 16));
        txn_ready = 1'b0;
        send_req('1, 3'd2);
        chk("R9 not ready", 64'(req_ready), 64'd0);
        fill(32'h0000_C000, 4);
        req_mask  = 32'h0000_000F;
        req_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R10 held base", 64'(txn_base), 64'hA000);
            chk("R10 held mask", 64'(txn_mask), 64'h0000_FFFF);
        end
        chk("R9 still closed", 64'(req_ready), 64'd0);
        req_valid = 1'b0;
        txn_ready = 1'b1;
        collect();
        chk("R9 count", 64'(n_tx), 64'd2);
        chk("R9 first base", 64'(rb[0]), 64'hA000);
        chk("R5 first size", 64'(rs[0]), 64'd1);
        chk("R9 second base", 64'(rb[1]), 64'hB000);
        chk("R9 second mask", 64'(rm[1]), 64'hFFFF_0000);
        @(negedge clk);
        chk("R9 no extra txn", 64'(txn_valid), 64'd0);
    endtask

    task automatic t_sizes();
        a[0] = 32'h0000_6010;
        send_req(32'h1, 3'd7);
        collect();
        chk("R11 128B base", 64'(rb[0]), 64'h6000);
        chk("R11 128B size", 64'(rs[0]), 64'd2);
        a[0] = 32'h0000_7044;
        send_req(32'h1, 3'd6);
        collect();
        chk("R11 64B base", 64'(rb[0]), 64'h7040);
        chk("R11 64B size", 64'(rs[0]), 64'd1);
        fill(32'h0000_8003, 1);
        send_req('1, 3'd0);
        collect();
        chk("R11 byte count", 64'(n_tx), 64'd1);
        chk("R11 byte base", 64'(rb[0]), 64'h8000);
        chk("R11 byte size", 64'(rs[0]), 64'd1);
        a[0] = 32'h0000_8025;
        send_req(32'h1, 3'd3);
        collect();
        chk("R11 8B base", 64'(rb[0]), 64'h8020);
        chk("R11 8B size", 64'(rs[0]), 64'd0);
    endtask

    initial begin
        fill('0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unit_stride();
        t_small_32();
        t_small_64();
        t_leader_order();
        t_scatter();
        t_empty();
        t_busy_stall();
        t_sizes();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule